// File: doc/BRIEF.md
# Packet-Stream to Memory-Mapped Read FIFO

This block sits between a packet-oriented streaming producer and a processor-style bus master. Beats arrive on a 32-bit streaming sink that carries valid/ready handshaking together with start-of-packet, end-of-packet, empty-symbol count, channel and error qualifiers. Each accepted beat and its qualifiers are held as one entry in a first-in first-out store.

A bus master drains the store through a 32-bit read-only slave with two word locations. Location 1 shows the qualifiers of the oldest entry without removing it. Location 0 returns the oldest data word and removes the entry in the same transaction. The stream sends its first symbol in the most significant bits, while the bus expects the first symbol at the lowest byte address. The block therefore reverses the symbol order of every word. Reads stall on waitrequest while nothing is buffered. When backpressure is disabled, ready stays high and beats that meet a full store are lost.

Top module: `st2mm_read_fifo`

## Requirements
- R1: Entries leave the store in the order the sink accepted them.
- R2: A location-0 read returns the accepted beat with its symbol order reversed. The symbol in the top bits of the stream word lands in the lowest symbol position. With 8-bit symbols and 4 per beat, 0x11223344 reads as 0x44332211. With 16-bit symbols and 2 per beat, 0xA000B000 reads as 0xB000A000.
- R3: The sink accepts a beat on a rising clock edge where valid and ready are both high.
- R4: With backpressure enabled, ready is low exactly while the store holds DEPTH entries.
- R5: waitrequest is high exactly while the store is empty. A pending read is held until an entry arrives.
- R6: A location-1 read returns the status word of the oldest entry and does not remove it. The status word has start-of-packet in bit 0, end-of-packet in bit 1, the empty count in bits 6:2, the channel in bits 15:8 and the error in bits 23:16.
- R7: Bit 7, bits 31:24, and any status bit above a narrower channel, error or empty field read as zero.
- R8: A location-0 read that completes (read high, waitrequest low at the clock edge) removes exactly one entry.
- R9: With backpressure disabled, ready is always high. A beat offered while the store is full is discarded and leaves the stored entries unchanged.
- R10: An accepted beat and a completing location-0 read in the same cycle leave the entry count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| snk_valid | input | 1 | Stream beat valid |
| snk_ready | output | 1 | Stream beat may be accepted |
| snk_data | input | 32 | Stream beat, first symbol in the top bits |
| snk_sop | input | 1 | Beat starts a packet |
| snk_eop | input | 1 | Beat ends a packet |
| snk_empty | input | EMPTY_W | Count of unused symbols in the beat |
| snk_channel | input | CHAN_W | Channel qualifier |
| snk_error | input | ERR_W | Error qualifier |
| mm_read | input | 1 | Bus read request |
| mm_addr | input | 1 | Word location: 0 data, 1 status |
| mm_rdata | output | 32 | Read data, valid while waitrequest is low |
| mm_waitrequest | output | 1 | Stall: no entry buffered |

## Verification
The bench builds two instances. The first uses the defaults: 8-bit symbols, four per beat, a 5-bit channel, a 3-bit error, eight entries and backpressure on. It exercises byte reversal, the zero padding above the narrow channel and error fields, ready dropping at full occupancy, and simultaneous push and pop under streaming load. The second uses 16-bit symbols, two per beat, full 8-bit channel and error fields, four entries and backpressure off. It reaches the half-word swap variant of the symbol reorder, the top bits of every status field, and the discard of beats that arrive while the store is full.

// File: rtl/st2mm_pkg.sv
package st2mm_pkg;

    // Width of both the bus data and the stream beat.
    localparam int MM_W = 32;

    // Status word layout (decoded by software, so positions are fixed).
    localparam int ST_SOP_BIT   = 0;
    localparam int ST_EOP_BIT   = 1;
    localparam int ST_EMPTY_LO  = 2;
    localparam int ST_EMPTY_MAX = 5;
    localparam int ST_CHAN_LO   = 8;
    localparam int ST_CHAN_MAX  = 8;
    localparam int ST_ERR_LO    = 16;
    localparam int ST_ERR_MAX   = 8;

    typedef enum logic {
        OFF_DATA   = 1'b0,
        OFF_STATUS = 1'b1
    } mm_off_e;

endpackage

// File: rtl/st2mm_sym_swap.sv
module st2mm_sym_swap #(
    parameter int SYM_W = 8,
    parameter int SYMS  = 4
) (
    input  logic [SYM_W*SYMS-1:0] din,
    output logic [SYM_W*SYMS-1:0] dout
);

    // Symbol i of the output takes symbol SYMS-1-i of the input.
    for (genvar i = 0; i < SYMS; i++) begin : g_sym
        assign dout[i*SYM_W +: SYM_W] = din[(SYMS-1-i)*SYM_W +: SYM_W];
    end

endmodule

// File: rtl/st2mm_status_pack.sv
module st2mm_status_pack
    import st2mm_pkg::*;
#(
    parameter int EMPTY_W = 2,
    parameter int CHAN_W  = 5,
    parameter int ERR_W   = 3
) (
    input  logic               sop,
    input  logic               eop,
    input  logic [EMPTY_W-1:0] empty,
    input  logic [CHAN_W-1:0]  chan,
    input  logic [ERR_W-1:0]   err,
    output logic [MM_W-1:0]    word
);

    // Every bit not written below stays zero (reserved and padding).
    always_comb begin
        word                          = '0;
        word[ST_SOP_BIT]              = sop;
        word[ST_EOP_BIT]              = eop;
        word[ST_EMPTY_LO +: EMPTY_W]  = empty;
        word[ST_CHAN_LO  +: CHAN_W]   = chan;
        word[ST_ERR_LO   +: ERR_W]    = err;
    end

endmodule

// File: rtl/st2mm_fifo_store.sv
module st2mm_fifo_store #(
    parameter int ENT_W        = 48,
    parameter int DEPTH        = 8,
    parameter int BACKPRESSURE = 1,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [ENT_W-1:0] in_entry,
    output logic             in_ready,
    input  logic             pop,
    output logic [ENT_W-1:0] head,
    output logic             empty,
    output logic [CW-1:0]    fill
);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [CW-1:0] cnt;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic full;
    logic push_ok;
    logic pop_ok;
    logic [ENT_W-1:0] mem_q [DEPTH];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (ctl_q.cnt == CW'(DEPTH));
    assign empty = (ctl_q.cnt == '0);
    assign fill  = ctl_q.cnt;
    assign head  = mem_q[ctl_q.rd];

    // Ready follows occupancy with backpressure; otherwise it is always open
    // and a beat meeting a full store is simply not written.
    if (BACKPRESSURE != 0) begin : g_bp
        assign in_ready = !full;
    end else begin : g_nobp
        assign in_ready = 1'b1;
    end

    assign push_ok = in_valid && !full;
    assign pop_ok  = pop && !empty;

    always_comb begin
        ctl_d = ctl_q;
        if (push_ok) begin
            ctl_d.wr = step(ctl_q.wr);
        end
        if (pop_ok) begin
            ctl_d.rd = step(ctl_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   ctl_d.cnt = ctl_q.cnt + 1'b1;
            2'b01:   ctl_d.cnt = ctl_q.cnt - 1'b1;
            default: ctl_d.cnt = ctl_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // Storage has no reset: an entry is only observed after it is written.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_q[ctl_q.wr] <= in_entry;
        end
    end

endmodule

// File: rtl/st2mm_read_fifo.sv
module st2mm_read_fifo
    import st2mm_pkg::*;
#(
    parameter int SYM_W        = 8,
    parameter int SYMS         = 4,
    parameter int CHAN_W       = 5,
    parameter int ERR_W        = 3,
    parameter int DEPTH        = 8,
    parameter int BACKPRESSURE = 1,
    parameter int EMPTY_W      = (SYMS > 1) ? $clog2(SYMS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               snk_valid,
    output logic               snk_ready,
    input  logic [MM_W-1:0]    snk_data,
    input  logic               snk_sop,
    input  logic               snk_eop,
    input  logic [EMPTY_W-1:0] snk_empty,
    input  logic [CHAN_W-1:0]  snk_channel,
    input  logic [ERR_W-1:0]   snk_error,
    input  logic               mm_read,
    input  logic               mm_addr,
    output logic [MM_W-1:0]    mm_rdata,
    output logic               mm_waitrequest
);

    localparam int ENT_W = MM_W + 2 + EMPTY_W + CHAN_W + ERR_W;
    localparam int CW    = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [ERR_W-1:0]   err;
        logic [CHAN_W-1:0]  chan;
        logic [EMPTY_W-1:0] empty;
        logic               eop;
        logic               sop;
        logic [MM_W-1:0]    data;
    } entry_t;

    typedef struct packed {
        logic            pop;
        logic [MM_W-1:0] rdata;
    } rsp_t;

    entry_t          wr_ent;
    entry_t          head_ent;
    logic [MM_W-1:0] data_mm;
    logic [MM_W-1:0] stat_word;
    logic            fifo_empty;
    logic [CW-1:0]   fill;
    rsp_t            rsp;

    // Reorder symbols once, on the way in, so the read path is a plain mux.
    st2mm_sym_swap #(
        .SYM_W (SYM_W),
        .SYMS  (SYMS)
    ) u_swap (
        .din  (snk_data),
        .dout (data_mm)
    );

    always_comb begin
        wr_ent.err   = snk_error;
        wr_ent.chan  = snk_channel;
        wr_ent.empty = snk_empty;
        wr_ent.eop   = snk_eop;
        wr_ent.sop   = snk_sop;
        wr_ent.data  = data_mm;
    end

    st2mm_fifo_store #(
        .ENT_W        (ENT_W),
        .DEPTH        (DEPTH),
        .BACKPRESSURE (BACKPRESSURE)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (snk_valid),
        .in_entry (wr_ent),
        .in_ready (snk_ready),
        .pop      (rsp.pop),
        .head     (head_ent),
        .empty    (fifo_empty),
        .fill     (fill)
    );

    st2mm_status_pack #(
        .EMPTY_W (EMPTY_W),
        .CHAN_W  (CHAN_W),
        .ERR_W   (ERR_W)
    ) u_stat (
        .sop   (head_ent.sop),
        .eop   (head_ent.eop),
        .empty (head_ent.empty),
        .chan  (head_ent.chan),
        .err   (head_ent.err),
        .word  (stat_word)
    );

    // Read response: zero-latency data, stalled while nothing is buffered.
    always_comb begin
        rsp.pop   = mm_read && !fifo_empty && (mm_off_e'(mm_addr) == OFF_DATA);
        rsp.rdata = (mm_off_e'(mm_addr) == OFF_STATUS) ? stat_word : head_ent.data;
    end

    assign mm_rdata       = rsp.rdata;
    assign mm_waitrequest = fifo_empty;

endmodule

// File: rtl/st2mm_read_fifo_chk.sv
module st2mm_read_fifo_chk #(
    parameter int DEPTH        = 8,
    parameter int BACKPRESSURE = 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          snk_valid,
    input logic          snk_ready,
    input logic          mm_read,
    input logic          mm_addr,
    input logic [31:0]   mm_rdata,
    input logic          mm_waitrequest,
    input logic [CW-1:0] fill
);

    logic push;
    logic done_rd;
    assign push    = snk_valid && snk_ready && (fill != CW'(DEPTH));
    assign done_rd = mm_read && !mm_waitrequest;

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CW'(DEPTH));

    assert_ready_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (BACKPRESSURE != 0 && fill == CW'(DEPTH)) |-> !snk_ready);

    assert_ready_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (fill < CW'(DEPTH)) |-> snk_ready);

    assert_wait_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) == mm_waitrequest);

    assert_push_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !(done_rd && !mm_addr)) |=> fill == $past(fill) + 1'b1);

    assert_pop_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd && !mm_addr && !push) |=> fill == $past(fill) - 1'b1);

    assert_both_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd && !mm_addr && push) |=> fill == $past(fill));

    assert_stat_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd && mm_addr && !push) |=> fill == $past(fill));

    assert_rsvd_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_rd && mm_addr) |-> (mm_rdata[31:24] == 8'h00 && !mm_rdata[7]));

endmodule

bind st2mm_read_fifo st2mm_read_fifo_chk #(
    .DEPTH        (DEPTH),
    .BACKPRESSURE (BACKPRESSURE)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .snk_valid      (snk_valid),
    .snk_ready      (snk_ready),
    .mm_read        (mm_read),
    .mm_addr        (mm_addr),
    .mm_rdata       (mm_rdata),
    .mm_waitrequest (mm_waitrequest),
    .fill           (fill)
);

// File: tb/st2mm_read_fifo_tb.sv
`timescale 1ns/1ps
module st2mm_read_fifo_tb;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;

    // Instance A: defaults (8-bit symbols x4, depth 8, backpressure)
    logic        a_valid = 0, a_ready, a_sop = 0, a_eop = 0;
    logic [31:0] a_data = 0, a_rdata;
    logic [1:0]  a_empty = 0;
    logic [4:0]  a_ch = 0;
    logic [2:0]  a_err = 0;
    logic        a_rd = 0, a_addr = 0, a_wait;

    // Instance B: 16-bit symbols x2, depth 4, no backpressure
    logic        b_valid = 0, b_ready, b_sop = 0, b_eop = 0;
    logic [31:0] b_data = 0, b_rdata;
    logic [0:0]  b_empty = 0;
    logic [7:0]  b_ch = 0;
    logic [7:0]  b_err = 0;
    logic        b_rd = 0, b_addr = 0, b_wait;

    st2mm_read_fifo u_dut (
        .clk(clk), .rst_n(rst_n),
        .snk_valid(a_valid), .snk_ready(a_ready), .snk_data(a_data),
        .snk_sop(a_sop), .snk_eop(a_eop), .snk_empty(a_empty),
        .snk_channel(a_ch), .snk_error(a_err),
        .mm_read(a_rd), .mm_addr(a_addr), .mm_rdata(a_rdata),
        .mm_waitrequest(a_wait)
    );

    st2mm_read_fifo #(
        .SYM_W(16), .SYMS(2), .CHAN_W(8), .ERR_W(8),
        .DEPTH(4), .BACKPRESSURE(0)
    ) u_dut_w16 (
        .clk(clk), .rst_n(rst_n),
        .snk_valid(b_valid), .snk_ready(b_ready), .snk_data(b_data),
        .snk_sop(b_sop), .snk_eop(b_eop), .snk_empty(b_empty),
        .snk_channel(b_ch), .snk_error(b_err),
        .mm_read(b_rd), .mm_addr(b_addr), .mm_rdata(b_rdata),
        .mm_waitrequest(b_wait)
    );

    logic [63:0] exp_q [$];   // {status, data} in bus view

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] swap8(input logic [31:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

    function automatic logic [31:0] swap16(input logic [31:0] d);
        return {d[15:0], d[31:16]};
    endfunction

    function automatic logic [31:0] stat(input logic sop, input logic eop,
        input logic [4:0] emp, input logic [7:0] ch, input logic [7:0] er);
        return {8'h00, er, ch, 1'b0, emp, eop, sop};
    endfunction

    // Driver: offers one beat, pushes the expectation when it is accepted.
    task automatic send_a(input logic [31:0] d, input logic sop, input logic eop,
        input logic [1:0] emp, input logic [4:0] ch, input logic [2:0] er);
        @(negedge clk);
        a_data = d; a_sop = sop; a_eop = eop; a_empty = emp; a_ch = ch; a_err = er;
        a_valid = 1'b1;
        forever begin
            #1;
            if (a_ready) begin
                @(posedge clk);
                exp_q.push_back({stat(sop, eop, {3'b0, emp}, {3'b0, ch}, {5'b0, er}),
                                 swap8(d)});
                #1 a_valid = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic read_a(input logic addr, output logic [31:0] v);
        @(negedge clk);
        a_rd = 1'b1; a_addr = addr;
        forever begin
            #1;
            if (!a_wait) begin
                v = a_rdata;
                @(posedge clk);
                #1 a_rd = 1'b0;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic read_b(input logic addr, output logic [31:0] v);
        @(negedge clk);
        b_rd = 1'b1; b_addr = addr;
        #1;
        v = b_rdata;
        chk(!b_wait, "R5 b entry present", {31'b0, b_wait}, 32'h0);
        @(posedge clk);
        #1 b_rd = 1'b0;
    endtask

    // Monitor: reads status then data of the head, compares with the queue.
    task automatic mon_a(input string tag);
        logic [31:0] s, d;
        logic [63:0] e;
        read_a(1'b1, s);
        read_a(1'b0, d);
        if (exp_q.size() == 0) begin
            chk(1'b0, {tag, " R1 unexpected entry"}, d, 32'h0);
        end else begin
            e = exp_q.pop_front();
            chk(s == e[63:32], {tag, " R6 status"}, s, e[63:32]);
            chk(d == e[31:0], {tag, " R1/R2 data order"}, d, e[31:0]);
        end
    endtask

    logic done = 0;

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] e;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // Reset state
        chk(a_ready, "R4 ready after reset", {31'b0, a_ready}, 32'h1);
        chk(a_wait,  "R5 wait after reset",  {31'b0, a_wait}, 32'h1);
        chk(b_ready, "R9 b ready after reset", {31'b0, b_ready}, 32'h1);
        chk(b_wait,  "R5 b wait after reset",  {31'b0, b_wait}, 32'h1);

        // Single beat: literal layout and byte reversal
        send_a(32'h11223344, 1'b1, 1'b1, 2'd1, 5'h1F, 3'h5);
        read_a(1'b1, v);
        chk(v == 32'h00051F07, "R6/R7 status layout", v, 32'h00051F07);
        read_a(1'b1, v);
        chk(v == 32'h00051F07, "R6 status reread keeps entry", v, 32'h00051F07);
        #1 chk(!a_wait, "R6 no pop on status read", {31'b0, a_wait}, 32'h0);
        read_a(1'b0, v);
        chk(v == 32'h44332211, "R2 byte reversal", v, 32'h44332211);
        #1 chk(a_wait, "R8 data read pops", {31'b0, a_wait}, 32'h1);
        void'(exp_q.pop_front());

        // Fill to capacity, check backpressure, then drain in order
        for (int k = 0; k < 8; k++) begin
            send_a(32'h0A0B0C00 + k, k == 0, k == 7, 2'(k), 5'(k + 3), 3'(k));
        end
        @(negedge clk); #1;
        chk(!a_ready, "R4 ready low when full", {31'b0, a_ready}, 32'h0);
        a_valid = 1'b1; a_data = 32'hDEADBEEF;
        repeat (2) @(negedge clk);
        #1 chk(!a_ready, "R3/R4 extra beat held off", {31'b0, a_ready}, 32'h0);
        a_valid = 1'b0;
        mon_a("fill0");
        #1 chk(a_ready, "R4 ready back after pop", {31'b0, a_ready}, 32'h1);
        for (int k = 1; k < 8; k++) mon_a("fill");
        #1 chk(a_wait, "R5 wait after drain", {31'b0, a_wait}, 32'h1);

        // Read issued on an empty store stalls until a beat arrives
        fork
            read_a(1'b1, v);
            begin
                repeat (3) @(negedge clk);
                #1 chk(a_wait && a_rd, "R5 read stalled while empty", {31'b0, a_wait}, 32'h1);
                send_a(32'hCAFE0123, 1'b1, 1'b0, 2'd3, 5'h02, 3'h1);
            end
        join
        e = exp_q.pop_front();
        chk(v == e[63:32], "R5 stalled status read completes", v, e[63:32]);
        read_a(1'b0, v);
        chk(v == 32'h2301FECA, "R2 stalled data read", v, 32'h2301FECA);

        // Streaming load: producer and consumer run concurrently
        fork
            for (int k = 0; k < 24; k++) begin
                send_a({8'(k), 8'(k * 3), 8'(k * 7), 8'hA5}, k % 6 == 0, k % 6 == 5,
                       2'(k), 5'(k), 3'(k));
            end
            for (int k = 0; k < 24; k++) mon_a("R10 stream");
        join
        #1 chk(exp_q.size() == 0, "R1 all beats returned", exp_q.size(), 32'h0);

        // No-backpressure instance: offer 6 beats back to back into depth 4
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            b_valid = 1'b1; b_data = 32'hA000B000 + k;
            b_sop = (k == 0); b_eop = (k == 5); b_empty = 1'(k);
            b_ch = 8'hC0 + 8'(k); b_err = 8'hF0 | 8'(k);
            #1 chk(b_ready, "R9 ready always high", {31'b0, b_ready}, 32'h1);
        end
        @(negedge clk) b_valid = 1'b0;
        for (int k = 0; k < 4; k++) begin
            logic [31:0] ed, es;
            ed = swap16(32'hA000B000 + k);
            es = stat(k == 0, 1'b0, 5'(k % 2), 8'hC0 + 8'(k), 8'hF0 | 8'(k));
            read_b(1'b1, v);
            chk(v == es, "R6/R9 b status", v, es);
            read_b(1'b0, v);
            chk(v == ed, "R2/R9 b half-word swap", v, ed);
        end
        #1 chk(b_wait, "R9 beats offered while full were dropped", {31'b0, b_wait}, 32'h1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule